// File: doc/BRIEF.md
# Two-Channel Action-Qualified PWM Generator

This block drives two pulse-width outputs from one shared up-counting time base. The counter advances on prescaled ticks and counts from zero up to a programmed period before it wraps. Each tick can raise up to three events for each channel: counter at zero, counter at period, and counter equal to that channel's compare value. The events do not set the output levels directly. Each channel holds a small action word that gives every event a 2-bit code meaning hold, drive low, drive high or toggle. Polarity, toggling waveforms and one-shot edges therefore come from reprogramming the action words alone.

A continuous software force can pin either output low or high and overrides the action result. A write loads the force value into a shadow copy. A reload-select field chooses when the shadow is copied into the active force: at counter zero, at period, at either of those, or at once. Software normally programs the period, compares, action words and force while the counter is stopped, and then sets the run bit. Configuration goes in through a plain write strobe with a 3-bit address.

Top module: `pwm_aq2`

## Requirements
- R1: The counter starts at 0 after reset. On each tick it increments. On the tick where it is at or above the period, it returns to 0 instead.
- R2: The write port takes the data on a clock edge where `wr_en` is 1. Address map: 0 period, 1 compare A, 2 compare B, 3 action word A, 4 action word B, 5 force word, 6 run (bit 0), 7 prescale divider. An action word holds 2-bit codes: bits [1:0] for the zero event, [3:2] for the period event, [5:4] for the compare event. Code 00 holds the output, 01 drives it low, 10 drives it high and 11 toggles it.
- R3: Action word 0x1A (high at zero and period, low at compare) with compare C < period P keeps the output high for C+1 ticks out of every P+1.
- R4: Action word 0x25 is the inverted form. With C < P the output is high for P-C ticks out of every P+1.
- R5: A compare value greater than the period never raises a compare event. With word 0x1A the output then stays high for the whole period.
- R6: When events coincide on one tick, only the highest-priority one acts: compare beats period, and period beats zero. With C = 0 and word 0x1A the output is high for 1 tick per period. With C = P it is high for P ticks.
- R7: While run is 0, the counter and prescaler hold still, no event fires and both outputs keep their levels.
- R8: With prescale divider D, one tick occurs every D+1 clocks while running. All waveform durations scale by D+1.
- R9: Force word bits [1:0] control output A and bits [3:2] control output B. For each output, 01 forces it low, 10 forces it high, and 00 or 11 leave the action result in control.
- R10: Force word bits [7:6] select when the shadow force becomes active. 00 loads it on the zero tick, 01 on the period tick, 10 on either tick, and 11 on the clock edge that takes the write.
- R11: Reset drives both outputs low and clears all registers, the force and the run bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Write data |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
The bench keeps the default 16-bit counter and 4-bit prescaler. It programs periods of only 3 to 20 ticks, so every waveform repeats many times inside a short run. Prescale dividers of 0, 1 and 2 exercise both a tick on every clock and stretched ticks. These short periods make the coincident-event corners (compare at 0, compare equal to period, compare beyond period) cheap to reach and measure by counting high clocks over two full periods. A mid-run reset places the counter at a known position, so the period-timed force reload can be checked against the zero-timed one.

// File: rtl/pwm_aq2.sv
module pwm_aq2 #(
  parameter int CW  = 16,
  parameter int PSW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          out_a,
  output logic          out_b
);
  localparam logic [2:0] AD_PRD  = 3'd0;
  localparam logic [2:0] AD_CMPA = 3'd1;
  localparam logic [2:0] AD_CMPB = 3'd2;
  localparam logic [2:0] AD_ACTA = 3'd3;
  localparam logic [2:0] AD_ACTB = 3'd4;
  localparam logic [2:0] AD_FRC  = 3'd5;
  localparam logic [2:0] AD_RUN  = 3'd6;
  localparam logic [2:0] AD_PS   = 3'd7;

  logic [CW-1:0]  prd, cmp_a, cmp_b, cnt;
  logic [5:0]     act_a, act_b;
  logic [3:0]     frc_sh, frc_on;
  logic [1:0]     rld_sel;
  logic           run, aq_a, aq_b;
  logic [PSW-1:0] ps_div, ps_cnt;

  function automatic logic aq_next(input logic cur, input logic [5:0] act,
                                   input logic ez, input logic ep, input logic ec);
    logic [1:0] code;
    if (ec)      code = act[5:4];
    else if (ep) code = act[3:2];
    else if (ez) code = act[1:0];
    else         code = 2'b00;
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  wire tick    = run && (ps_cnt == ps_div);
  wire ev_zero = tick && (cnt == '0);
  wire ev_prd  = tick && (cnt == prd);
  wire ev_ca   = tick && (cnt == cmp_a) && (cmp_a <= prd);
  wire ev_cb   = tick && (cnt == cmp_b) && (cmp_b <= prd);
  wire wrap    = cnt >= prd;

  wire rld_hit = (rld_sel == 2'b00 && ev_zero) ||
                 (rld_sel == 2'b01 && ev_prd)  ||
                 (rld_sel == 2'b10 && (ev_zero || ev_prd));
  wire frc_now = wr_en && (wr_addr == AD_FRC) && (wr_data[7:6] == 2'b11);

  wire frc_act_a = frc_on[1] ^ frc_on[0];
  wire frc_act_b = frc_on[3] ^ frc_on[2];

  assign out_a = frc_act_a ? frc_on[1] : aq_a;
  assign out_b = frc_act_b ? frc_on[3] : aq_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd <= '0; cmp_a <= '0; cmp_b <= '0;
      act_a <= '0; act_b <= '0;
      frc_sh <= '0; rld_sel <= '0;
      run <= 1'b0; ps_div <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AD_PRD:  prd   <= wr_data;
        AD_CMPA: cmp_a <= wr_data;
        AD_CMPB: cmp_b <= wr_data;
        AD_ACTA: act_a <= wr_data[5:0];
        AD_ACTB: act_b <= wr_data[5:0];
        AD_FRC: begin
          frc_sh  <= wr_data[3:0];
          rld_sel <= wr_data[7:6];
        end
        AD_RUN:  run    <= wr_data[0];
        default: ps_div <= wr_data[PSW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_cnt <= '0;
      cnt    <= '0;
    end else if (run) begin
      if (tick) begin
        ps_cnt <= '0;
        cnt    <= wrap ? '0 : cnt + 1'b1;
      end else begin
        ps_cnt <= ps_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aq_a   <= 1'b0;
      aq_b   <= 1'b0;
      frc_on <= '0;
    end else begin
      aq_a <= aq_next(aq_a, act_a, ev_zero, ev_prd, ev_ca);
      aq_b <= aq_next(aq_b, act_b, ev_zero, ev_prd, ev_cb);
      if (frc_now)      frc_on <= wr_data[3:0];
      else if (rld_hit) frc_on <= frc_sh;
    end
  end

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cnt >= prd) |=> cnt == '0);

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt) && $stable(aq_a) && $stable(aq_b));

  // R8
  ps_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (ps_div != '0) && !(wr_en && wr_addr == AD_PS) |=> !tick);

  // R6
  cmp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cnt == cmp_a) && (cmp_a <= prd) && (act_a[5:4] == 2'b01) |=> !out_a || frc_act_a);

  // R9
  frc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_addr == AD_FRC) && (wr_data[7:6] == 2'b11) && (wr_data[1:0] == 2'b01) |=> !out_a);
endmodule

// File: tb/sim_pwm_aq2.sv
`timescale 1ns/1ps
module sim_pwm_aq2;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic out_a, out_b;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_aq2 u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
              .wr_data(wr_data), .out_a(out_a), .out_b(out_b));

  // period, cmpA, cmpB, actA, actB, prescale, high ticks A / B over two periods
  localparam int VEC [0:5][0:7] = '{
    '{9, 4, 7, 'h1A, 'h1A, 0, 10, 16},
    '{9, 4, 7, 'h25, 'h1A, 0, 10, 16},
    '{5, 0, 6, 'h1A, 'h1A, 0,  2, 12},
    '{5, 5, 3, 'h1A, 'h25, 2, 10,  4},
    '{7, 1, 2, 'h03, 'h1A, 0,  8,  6},
    '{3, 1, 3, 'h25, 'h25, 1,  4,  2}
  };
  string vname [0:5] = '{"R3 R2 normal", "R4 inverted A", "R6 R5 cmp=0, cmp>prd",
                         "R6 R8 cmp=prd, prescale 2", "R1 R2 toggle", "R4 R8 prescale 1"};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int n, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ha += int'(out_a); hb += int'(out_b);
    end
  endtask

  initial begin
    int ha, hb, per, va, vb, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset out_a", int'(out_a), 0);
    chk("R11 reset out_b", int'(out_b), 0);

    for (int i = 0; i < 6; i++) begin
      wr(3'd0, VEC[i][0]); wr(3'd1, VEC[i][1]); wr(3'd2, VEC[i][2]);
      wr(3'd3, VEC[i][3]); wr(3'd4, VEC[i][4]); wr(3'd7, VEC[i][5]);
      wr(3'd6, 1);
      per = (VEC[i][0] + 1) * (VEC[i][5] + 1);
      repeat (3 * per) @(negedge clk);
      measure(2 * per, ha, hb);
      chk({vname[i], " A"}, ha, VEC[i][6] * (VEC[i][5] + 1));
      chk({vname[i], " B"}, hb, VEC[i][7] * (VEC[i][5] + 1));
    end

    // R7 stopped counter keeps outputs
    wr(3'd6, 0);
    va = int'(out_a); vb = int'(out_b); bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (int'(out_a) != va || int'(out_b) != vb) bad++;
    end
    chk("R7 stopped outputs hold", bad, 0);

    // R9 force low/high, immediate load
    wr(3'd0, 9); wr(3'd1, 4); wr(3'd2, 7); wr(3'd3, 'h1A); wr(3'd4, 'h1A);
    wr(3'd7, 0); wr(3'd6, 1);
    wr(3'd5, 'hC9);
    chk("R9 R10 immediate force A low", int'(out_a), 0);
    chk("R9 R10 immediate force B high", int'(out_b), 1);
    measure(20, ha, hb);
    chk("R9 forced A high count", ha, 0);
    chk("R9 forced B high count", hb, 20);
    wr(3'd5, 'hCF);
    repeat (30) @(negedge clk);
    measure(20, ha, hb);
    chk("R9 code 11 releases A", ha, 10);
    chk("R9 code 11 releases B", hb, 16);

    // R10 zero-timed reload waits for a tick
    wr(3'd6, 0);
    va = int'(out_a);
    wr(3'd5, 'h02);
    repeat (10) @(negedge clk);
    chk("R10 shadow not loaded while stopped", int'(out_a), va);
    wr(3'd6, 1);
    repeat (30) @(negedge clk);
    measure(20, ha, hb);
    chk("R10 zero reload forces A high", ha, 20);

    // R10 period-timed reload, counter known from reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 mid-run reset out_a", int'(out_a), 0);
    wr(3'd0, 20); wr(3'd1, 10); wr(3'd3, 'h1A); wr(3'd5, 'h42);
    wr(3'd6, 1);
    repeat (15) @(negedge clk);
    chk("R10 period reload not yet active", int'(out_a), 0);
    repeat (10) @(negedge clk);
    chk("R10 period reload active", int'(out_a), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule